// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reason a chip may need to restart into a single active-low system reset. Six sources feed it: the power-good input (the power-on reset), a bidirectional reset pin, the expiry of a window watchdog, the expiry of a free-running independent watchdog, a software reset request and a reset request from low-power management. The pin is read through a synchronizer and a glitch filter. Any accepted request starts, or restarts, a counter that holds the reset output low for a guaranteed minimum number of clock cycles. The same pulse pulls the reset pin low, so that circuits outside the chip restart together with it.

Six sticky cause flags record which sources requested a reset. The system reset does not touch them, so software can read them after the restart. Only a power-on reset or an explicit clear strobe changes them. A power-on reset leaves only its own flag set. All state of the block is cleared by the power-good input alone, so the block never resets itself.

The minimum pulse width is derived from a reference clock frequency and a pulse duration in microseconds. The default is 20 µs at 8 MHz, which is 160 cycles.

Top module: `sysrst_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n_o` is low and `cause_flags_o` equals 6'b000001, with only the power-on flag at bit 0 set. After `por_n` rises, `sys_rst_n_o` rises on the PULSE_CYC-th rising clock edge.
- R2: A high level on `win_wdog_expire_i`, `ind_wdog_expire_i`, `sw_rst_req_i` or `lpm_rst_req_i`, or an accepted pin request, drives `sys_rst_n_o` low from the next rising clock edge.
- R3: The reset output stays low for exactly PULSE_CYC cycles after the last cycle in which a request was present. PULSE_CYC = (REF_CLK_HZ / 1_000_000) * PULSE_US, which is 160 by default.
- R4: A low on `pin_level_i` becomes a request only after the synchronized pin has been low on FILT_CYC consecutive clock edges (default 4). A shorter low pulse causes no reset and sets no flag.
- R5: `pin_pull_low_o` is high exactly while `sys_rst_n_o` is low.
- R6: The block's own pull on the pin never turns into a pin request. The pin input is ignored while the pin is being pulled low and for SYNC_STAGES+1 cycles after the pull ends.
- R7: A high `flag_clr_i` clears all six flags at the next edge. A request present in the same cycle still sets its own flag.
- R8: The flags are sticky and survive the system reset. The bit positions are: 0 power-on, 1 pin, 2 window watchdog, 3 independent watchdog, 4 software, 5 low-power management.
- R9: When several sources request a reset in the same cycle, each of them sets its own flag.
- R10: A request that arrives while the reset is already active reloads the width counter, so the reset is extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-good, active low; asynchronous power-on reset of all state |
| pin_level_i | input | 1 | Level read back from the bidirectional reset pin, low means reset |
| pin_pull_low_o | output | 1 | Open-drain pull enable for the reset pin |
| win_wdog_expire_i | input | 1 | Window watchdog end-of-count |
| ind_wdog_expire_i | input | 1 | Independent watchdog end-of-count |
| sw_rst_req_i | input | 1 | Software reset request |
| lpm_rst_req_i | input | 1 | Low-power-management reset request |
| flag_clr_i | input | 1 | Strobe that clears all cause flags |
| sys_rst_n_o | output | 1 | Active-low system reset |
| cause_flags_o | output | 6 | Sticky reset cause flags |

## Verification
Assertions check the following on every cycle:
- every request pulls the reset low at the next edge;
- no rising reset output comes after fewer than PULSE_CYC low cycles;
- flags only ever gain bits unless a clear is strobed, and a clear leaves exactly the bits that were set in the same cycle;
- the pin filter raises no request in the cycle after its own pull was active.

Some behaviours only the directed scenarios can show:
- the exact filter threshold, where FILT_CYC-1 low cycles are ignored and FILT_CYC are accepted;
- the power-on flag value and the release timing after power-on;
- several flags set together by simultaneous sources;
- the total length of a reset extended by a second request;
- the absence of a second pulse once the pin is released.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int CAUSE_W = 6;

    typedef enum int unsigned {
        CAUSE_POR = 0,
        CAUSE_PIN = 1,
        CAUSE_WIN = 2,
        CAUSE_IND = 3,
        CAUSE_SW  = 4,
        CAUSE_LPM = 5
    } cause_idx_e;

    typedef logic [CAUSE_W-1:0] cause_vec_t;

endpackage

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_level_i,
    input  logic drive_low_i,
    output logic req_o
);
    localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam int GUARD = SYNC_STAGES + 1;
    localparam int GRD_W = $clog2(GUARD + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_CYC - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic [GRD_W-1:0]       guard;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic        masked;
    logic        pin_low;

    always_comb begin
        st_d    = st_q;
        masked  = drive_low_i || (st_q.guard != '0);
        pin_low = !st_q.sync[SYNC_STAGES-1];

        // shift register synchronizer, newest sample in bit 0
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_level_i};

        // blanking window covering our own pull and the synchronizer latency
        if (drive_low_i) begin
            st_d.guard = GRD_W'(GUARD);
        end else if (st_q.guard != '0) begin
            st_d.guard = st_q.guard - 1'b1;
        end

        // consecutive-low counter, saturating at FILT_CYC-1
        if (masked || !pin_low) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_TOP) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        req_o = pin_low && !masked && (st_q.cnt == CNT_TOP);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.sync  <= '1;
            st_q.cnt   <= '0;
            st_q.guard <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: one cycle after the pull was active the filter must still be blind
    assert_no_self_trigger_R6: assert property (@(posedge clk) disable iff (!por_n)
        $past(drive_low_i) |-> !req_o);

endmodule

// File: rtl/sysrst_pulse_stretch.sv
module sysrst_pulse_stretch #(
    parameter int PULSE_CYC = 160
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_i,
    output logic rst_n_o
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst_n;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_i) begin
            st_d.cnt = CNT_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.rst_n = (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cnt   <= CNT_LOAD;
            st_q.rst_n <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_o = st_q.rst_n;

    // checker: length of the current low run of the reset output
    logic [CNT_W-1:0] chk_run_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chk_run_q <= '0;
        end else if (!st_q.rst_n) begin
            if (chk_run_q != CNT_LOAD) chk_run_q <= chk_run_q + 1'b1;
        end else begin
            chk_run_q <= '0;
        end
    end

    // R2: a request is visible on the reset output at the next edge
    assert_req_asserts_R2: assert property (@(posedge clk) disable iff (!por_n)
        req_i |=> !rst_n_o);

    // R3: no release before the minimum number of low cycles
    assert_min_width_R3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n_o) |-> (chk_run_q >= CNT_LOAD));

endmodule

// File: rtl/sysrst_cause_flags.sv
module sysrst_cause_flags
    import sysrst_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  cause_vec_t set_i,
    input  logic       clr_i,
    output cause_vec_t flags_o
);
    typedef struct packed {
        cause_vec_t flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flags = '0;
        end
        // a cause in the clearing cycle survives the clear
        st_d.flags = st_d.flags | set_i;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.flags <= cause_vec_t'(1) << CAUSE_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    // R8: without a clear no flag ever falls
    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R7: after a clear only the causes of the clearing cycle remain
    assert_clear_keeps_new_R7: assert property (@(posedge clk) disable iff (!por_n)
        clr_i |=> (flags_o == $past(set_i)));

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int REF_CLK_HZ  = 8_000_000,
    parameter int PULSE_US    = 20,
    parameter int FILT_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                pin_level_i,
    output logic                pin_pull_low_o,
    input  logic                win_wdog_expire_i,
    input  logic                ind_wdog_expire_i,
    input  logic                sw_rst_req_i,
    input  logic                lpm_rst_req_i,
    input  logic                flag_clr_i,
    output logic                sys_rst_n_o,
    output logic [CAUSE_W-1:0]  cause_flags_o
);
    localparam int PULSE_CYC = (REF_CLK_HZ / 1_000_000) * PULSE_US;

    logic       pin_req;
    logic       any_req;
    logic       rst_n;
    cause_vec_t cause_set;
    cause_vec_t flags;

    sysrst_pin_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_CYC    (FILT_CYC)
    ) u_filter (
        .clk         (clk),
        .por_n       (por_n),
        .pin_level_i (pin_level_i),
        .drive_low_i (pin_pull_low_o),
        .req_o       (pin_req)
    );

    always_comb begin
        cause_set            = '0;
        cause_set[CAUSE_PIN] = pin_req;
        cause_set[CAUSE_WIN] = win_wdog_expire_i;
        cause_set[CAUSE_IND] = ind_wdog_expire_i;
        cause_set[CAUSE_SW]  = sw_rst_req_i;
        cause_set[CAUSE_LPM] = lpm_rst_req_i;
        any_req              = |cause_set;
    end

    sysrst_pulse_stretch #(
        .PULSE_CYC (PULSE_CYC)
    ) u_stretch (
        .clk     (clk),
        .por_n   (por_n),
        .req_i   (any_req),
        .rst_n_o (rst_n)
    );

    sysrst_cause_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .set_i   (cause_set),
        .clr_i   (flag_clr_i),
        .flags_o (flags)
    );

    assign sys_rst_n_o    = rst_n;
    assign pin_pull_low_o = !rst_n;
    assign cause_flags_o  = flags;

endmodule

// File: tb/sim_sysrst_ctrl.sv
module sim_sysrst_ctrl;
    localparam int FILT      = 4;
    localparam int PULSE_CYC = 160;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_low = 1'b0;
    logic       pin_pull_low;
    logic       win = 1'b0, ind = 1'b0, sw = 1'b0, lpm = 1'b0, clr = 1'b0;
    logic       rst_n;
    logic [5:0] flags;
    logic       pin_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign pin_line = !(ext_low || pin_pull_low);

    sysrst_ctrl #(
        .REF_CLK_HZ(8_000_000), .PULSE_US(20), .FILT_CYC(FILT), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .por_n(por_n), .pin_level_i(pin_line),
        .pin_pull_low_o(pin_pull_low), .win_wdog_expire_i(win),
        .ind_wdog_expire_i(ind), .sw_rst_req_i(sw), .lpm_rst_req_i(lpm),
        .flag_clr_i(clr), .sys_rst_n_o(rst_n), .cause_flags_o(flags)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count consecutive low samples of the reset, starting with the current one
    task automatic measure_low(output int n);
        n = 0;
        while (!rst_n && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags();
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
    endtask

    task automatic t_por();
        int n;
        chk(rst_n == 1'b0, "R1 reset low during por", rst_n, 0);
        chk(flags == 6'b000001, "R1 por flag value", flags, 1);
        chk(pin_pull_low == 1'b1, "R5 pin pulled during por", pin_pull_low, 1);
        por_n = 1'b1;
        cyc(1);
        measure_low(n);
        chk(n == PULSE_CYC - 1, "R1 release after por", n, PULSE_CYC - 1);
        chk(flags == 6'b000001, "R1 flag after por release", flags, 1);
        chk(pin_pull_low == 1'b0, "R5 pin released", pin_pull_low, 0);
    endtask

    task automatic t_clear();
        clear_flags();
        chk(flags == 6'b0, "R7 clear strobe", flags, 0);
    endtask

    task automatic t_software();
        int n;
        sw = 1'b1;
        cyc(1);
        sw = 1'b0;
        chk(rst_n == 1'b0, "R2 sw reset asserts", rst_n, 0);
        chk(pin_pull_low == 1'b1, "R5 pin pulled by sw reset", pin_pull_low, 1);
        measure_low(n);
        chk(n == PULSE_CYC, "R3 pulse width", n, PULSE_CYC);
        chk(flags == 6'b010000, "R8 sw flag at bit 4", flags, 6'b010000);
    endtask

    task automatic t_sticky();
        int n;
        win = 1'b1;
        cyc(1);
        win = 1'b0;
        measure_low(n);
        chk(flags == 6'b010100, "R8 flags survive reset", flags, 6'b010100);
    endtask

    task automatic t_multi();
        int n;
        clear_flags();
        win = 1'b1;
        ind = 1'b1;
        cyc(1);
        win = 1'b0;
        ind = 1'b0;
        measure_low(n);
        chk(flags == 6'b001100, "R9 simultaneous causes", flags, 6'b001100);
    endtask

    task automatic t_extend();
        int n;
        int lows = 0;
        clear_flags();
        lpm = 1'b1;
        cyc(1);
        lpm = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (!rst_n) lows++;
            if (i < 9) cyc(1);
        end
        chk(lows == 10, "R10 reset held before retrigger", lows, 10);
        lpm = 1'b1;
        cyc(1);
        lpm = 1'b0;
        measure_low(n);
        chk(n == PULSE_CYC, "R10 width after retrigger", n, PULSE_CYC);
        chk(flags == 6'b100000, "R8 lpm flag at bit 5", flags, 6'b100000);
    endtask

    task automatic t_glitch();
        int lows = 0;
        clear_flags();
        ext_low = 1'b1;
        cyc(FILT - 1);
        ext_low = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (!rst_n) lows++;
            cyc(1);
        end
        chk(lows == 0, "R4 short glitch ignored", lows, 0);
        chk(flags == 6'b0, "R4 glitch sets no flag", flags, 0);
    endtask

    task automatic t_pin();
        int n;
        int w = 0;
        int lows = 0;
        ext_low = 1'b1;
        cyc(FILT);
        ext_low = 1'b0;
        while (rst_n && w < 20) begin
            w++;
            cyc(1);
        end
        chk(rst_n == 1'b0, "R4 filtered pin low accepted", rst_n, 0);
        measure_low(n);
        chk(n == PULSE_CYC, "R3 pin pulse width", n, PULSE_CYC);
        chk(flags == 6'b000010, "R8 pin flag at bit 1", flags, 6'b000010);
        for (int i = 0; i < 30; i++) begin
            if (!rst_n) lows++;
            cyc(1);
        end
        chk(lows == 0, "R6 no retrigger from own pull", lows, 0);
        chk(flags == 6'b000010, "R6 flags unchanged after release", flags, 6'b000010);
    endtask

    task automatic t_clear_and_set();
        int n;
        clr = 1'b1;
        sw = 1'b1;
        cyc(1);
        clr = 1'b0;
        sw = 1'b0;
        chk(flags == 6'b010000, "R7 request wins over clear", flags, 6'b010000);
        measure_low(n);
    endtask

    task automatic t_por_again();
        por_n = 1'b0;
        #1;
        chk(flags == 6'b000001, "R1 por clears other flags", flags, 1);
        chk(rst_n == 1'b0, "R1 por asserts reset", rst_n, 0);
        cyc(2);
        por_n = 1'b1;
        cyc(PULSE_CYC + 2);
        chk(rst_n == 1'b1, "R1 released after por", rst_n, 1);
    endtask

    initial begin
        cyc(3);
        t_por();
        t_clear();
        t_software();
        t_sticky();
        t_multi();
        t_extend();
        t_glitch();
        t_pin();
        t_clear_and_set();
        t_por_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule